// File: doc/BRIEF.md
# High-Speed Entry Sequencer for a Serial Display Lane

This block controls one lane of a low-swing differential display link. It moves the lane between the idle low-power stop state, the high-speed transmit state and the ultra-low-power sleep state. Each state change is a fixed series of line states. Every step of the series lasts a number of byte-clock cycles, and those counts come from 8-bit fields packed into four 32-bit timing words. A lower level of the design supplies three control levels: high-speed enable, sleep enable and wake. The block returns the low-power line levels, an enable for the high-speed driver, a window that marks when payload bytes may be sent, and a code for the current step.

The parameter `CLOCK_LANE` picks which timing fields are used. A data lane reads its prepare, zero, trail and exit counts from words 0 and 1. A clock lane takes the same steps from its own fields in words 2 and 3. Both lane types use the LPX count in word 0 bits 7:0. A sequence that has started always runs to its end. A request is acted on only from a state in which it makes sense. The lane leaves sleep only when sleep enable has been cleared and wake is then pulsed high and back low.

All pins are plain control and status levels. No data stream passes through the block, so no pin has a valid/ready handshake.

Top module: `lane_hs_seq`

## Requirements
- R1: After reset the step code is 0 (stop), `lp_line` is 2'b11 (bit 1 = positive wire, bit 0 = negative wire), and `hs_drive` and `hs_window` are both 0.
- R2: In stop with `hs_en` high and `ulp_en` low, the lane enters step 1 (LP-01, `lp_line`=2'b01) for LPX cycles. It then enters step 2 (LP-00, `lp_line`=2'b00) for the prepare count.
- R3: After prepare, step 3 (zero) holds `hs_drive`=1 and `hs_window`=0 for the zero count. Step 4 (high-speed) then follows, with `hs_drive`=1 and `hs_window`=1.
- R4: In step 4 with `hs_en` low, the lane enters step 5 (trail, `hs_drive`=1, `hs_window`=0) for the trail count. It then enters step 6 (`lp_line`=2'b11, drivers off) for the exit count, and then returns to step 0.
- R5: A timing field that holds 0 lasts exactly one cycle. A field that holds N, where N ≥ 1, lasts exactly N cycles.
- R6: Data lane fields are LPX = word0[7:0], prepare = word0[15:8], zero = word0[23:16], trail = word0[31:24] and exit = word1[31:24].
- R7: Clock lane fields are LPX = word0[7:0], prepare = word3[7:0], zero = word2[23:16], trail = word2[31:24] and exit = word3[23:16].
- R8: An entry that has started always reaches step 4, even if `hs_en` falls during steps 1 to 3. If `hs_en` is then low, trail starts on the next cycle.
- R9: While in step 4, a high `hs_en` keeps the lane there and `ulp_en` has no effect.
- R10: In stop with `ulp_en` high, the lane enters step 7 (sleep, `lp_line`=2'b00). `ulp_en` wins over `hs_en`.
- R11: In sleep, `wake` is ignored while `ulp_en` is high. With `ulp_en` low and `wake` high, the lane enters step 8 (mark, `lp_line`=2'b10). When `wake` falls it returns to step 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hs_en | input | 1 | High-speed transmit enable level |
| ulp_en | input | 1 | Sleep (ultra-low-power) enable level |
| wake | input | 1 | Wake pulse used to leave sleep |
| tim_w0 | input | 32 | Timing word 0 |
| tim_w1 | input | 32 | Timing word 1 |
| tim_w2 | input | 32 | Timing word 2 |
| tim_w3 | input | 32 | Timing word 3 |
| lp_line | output | 2 | Low-power line levels {positive, negative} |
| hs_drive | output | 1 | High-speed driver enable |
| hs_window | output | 1 | Payload window |
| step | output | 4 | Current step code |

## Verification
A wrong dwell count shows up as a step run that is one or more cycles too long or too short. The bench measures the length of every step's run directly at `step`, so a counter off by one shows within the first entry. A wrong transition shows on the next clock as an unexpected step code or the wrong `lp_line` level. A field read from the wrong lane's word set shows as a run length that matches the other lane's value. The two lanes are given different values so that such a mix-up is visible.

// File: rtl/lane_seq_pkg.sv
package lane_seq_pkg;
  localparam int FW = 8;

  typedef enum logic [3:0] {
    ST_STOP  = 4'd0,
    ST_REQ   = 4'd1,
    ST_PREP  = 4'd2,
    ST_ZERO  = 4'd3,
    ST_HS    = 4'd4,
    ST_TRAIL = 4'd5,
    ST_EXIT  = 4'd6,
    ST_ULPS  = 4'd7,
    ST_MARK  = 4'd8
  } lane_st_e;

  typedef struct packed {
    logic [FW-1:0] lpx;
    logic [FW-1:0] prep;
    logic [FW-1:0] zero;
    logic [FW-1:0] trail;
    logic [FW-1:0] settle;
  } lane_tim_t;

  // zero-valued field still occupies one cycle
  function automatic logic [FW-1:0] at_least_one(input logic [FW-1:0] v);
    return (v == '0) ? FW'(1) : v;
  endfunction
endpackage

// File: rtl/lane_timing_sel.sv
module lane_timing_sel
  import lane_seq_pkg::*;
#(
  parameter bit CLOCK_LANE = 1'b0,
  parameter int WORD_W     = 32
) (
  input  logic [WORD_W-1:0] w0,
  input  logic [WORD_W-1:0] w1,
  input  logic [WORD_W-1:0] w2,
  input  logic [WORD_W-1:0] w3,
  output lane_tim_t         tim
);
  localparam int B1 = FW;
  localparam int B2 = 2 * FW;
  localparam int B3 = 3 * FW;

  lane_tim_t raw;

  generate
    if (CLOCK_LANE) begin : g_clk
      always_comb begin
        raw.lpx    = w0[FW-1:0];
        raw.prep   = w3[FW-1:0];
        raw.zero   = w2[B2 +: FW];
        raw.trail  = w2[B3 +: FW];
        raw.settle = w3[B2 +: FW];
      end
      logic unused_clk_bits;
      assign unused_clk_bits = ^{w0[WORD_W-1:FW], w1, w2[B2-1:0], w3[WORD_W-1:B3], w3[B1 +: FW]};
    end else begin : g_data
      always_comb begin
        raw.lpx    = w0[FW-1:0];
        raw.prep   = w0[B1 +: FW];
        raw.zero   = w0[B2 +: FW];
        raw.trail  = w0[B3 +: FW];
        raw.settle = w1[B3 +: FW];
      end
      logic unused_data_bits;
      assign unused_data_bits = ^{w1[B3-1:0], w2, w3};
    end
  endgenerate

  always_comb begin
    tim.lpx    = at_least_one(raw.lpx);
    tim.prep   = at_least_one(raw.prep);
    tim.zero   = at_least_one(raw.zero);
    tim.trail  = at_least_one(raw.trail);
    tim.settle = at_least_one(raw.settle);
  end
endmodule

// File: rtl/lane_dwell_timer.sv
module lane_dwell_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt > CW'(1)) cnt <= cnt - CW'(1);
  end

  assign done = (cnt <= CW'(1));
endmodule

// File: rtl/lane_seq_fsm.sv
module lane_seq_fsm
  import lane_seq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hs_en,
  input  logic          ulp_en,
  input  logic          wake,
  input  lane_tim_t     tim,
  input  logic          done,
  output lane_st_e      st,
  output logic          load,
  output logic [FW-1:0] load_val
);
  lane_st_e nxt;

  always_comb begin
    nxt      = st;
    load     = 1'b0;
    load_val = tim.lpx;
    unique case (st)
      ST_STOP: begin
        if (ulp_en) nxt = ST_ULPS;
        else if (hs_en) begin
          nxt = ST_REQ; load = 1'b1; load_val = tim.lpx;
        end
      end
      ST_REQ: if (done) begin
        nxt = ST_PREP; load = 1'b1; load_val = tim.prep;
      end
      ST_PREP: if (done) begin
        nxt = ST_ZERO; load = 1'b1; load_val = tim.zero;
      end
      ST_ZERO: if (done) nxt = ST_HS;
      ST_HS: if (!hs_en) begin
        nxt = ST_TRAIL; load = 1'b1; load_val = tim.trail;
      end
      ST_TRAIL: if (done) begin
        nxt = ST_EXIT; load = 1'b1; load_val = tim.settle;
      end
      ST_EXIT: if (done) nxt = ST_STOP;
      ST_ULPS: if (!ulp_en && wake) nxt = ST_MARK;
      ST_MARK: if (!wake) nxt = ST_STOP;
      default: nxt = ST_STOP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_STOP;
    else        st <= nxt;
  end
endmodule

// File: rtl/lane_hs_seq.sv
module lane_hs_seq
  import lane_seq_pkg::*;
#(
  parameter bit CLOCK_LANE = 1'b0,
  parameter int WORD_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hs_en,
  input  logic              ulp_en,
  input  logic              wake,
  input  logic [WORD_W-1:0] tim_w0,
  input  logic [WORD_W-1:0] tim_w1,
  input  logic [WORD_W-1:0] tim_w2,
  input  logic [WORD_W-1:0] tim_w3,
  output logic [1:0]        lp_line,
  output logic              hs_drive,
  output logic              hs_window,
  output logic [3:0]        step
);
  lane_tim_t     tim;
  lane_st_e      st;
  logic          load, done;
  logic [FW-1:0] load_val;

  lane_timing_sel #(.CLOCK_LANE(CLOCK_LANE), .WORD_W(WORD_W)) u_sel (
    .w0(tim_w0), .w1(tim_w1), .w2(tim_w2), .w3(tim_w3), .tim(tim)
  );

  lane_dwell_timer #(.CW(FW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .done(done)
  );

  lane_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .hs_en(hs_en), .ulp_en(ulp_en), .wake(wake),
    .tim(tim), .done(done), .st(st), .load(load), .load_val(load_val)
  );

  always_comb begin
    unique case (st)
      ST_STOP, ST_EXIT: lp_line = 2'b11;
      ST_REQ:           lp_line = 2'b01;
      ST_MARK:          lp_line = 2'b10;
      default:          lp_line = 2'b00;
    endcase
  end

  assign hs_drive  = (st == ST_ZERO) || (st == ST_HS) || (st == ST_TRAIL);
  assign hs_window = (st == ST_HS);
  assign step      = st;
endmodule

// File: rtl/lane_hs_seq_chk.sv
module lane_hs_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hs_en,
  input logic       ulp_en,
  input logic       wake,
  input logic [1:0] lp_line,
  input logic       hs_drive,
  input logic       hs_window,
  input logic [3:0] step
);
  // R3: the payload window never opens without the driver on
  assert_window_driven_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hs_window |-> hs_drive);

  // R2: LP-01 is followed only by itself or by prepare
  assert_req_to_prep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step == 4'd1) |=> (step == 4'd1 || step == 4'd2));

  // R3: the window only opens directly after the zero step
  assert_window_after_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_window) |-> ($past(step) == 4'd3));

  // R4: dropping the enable in high-speed starts trail on the next cycle
  assert_exit_to_trail_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step == 4'd4 && !hs_en) |=> (step == 4'd5));

  // R9: high-speed holds while the enable stays high
  assert_hs_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (step == 4'd4 && hs_en) |=> (step == 4'd4));

  // R11: sleep holds unless enable is cleared and wake is high
  assert_ulps_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (step == 4'd7 && (ulp_en || !wake)) |=> (step == 4'd7 && lp_line == 2'b00));
endmodule

bind lane_hs_seq lane_hs_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hs_en(hs_en), .ulp_en(ulp_en), .wake(wake),
  .lp_line(lp_line), .hs_drive(hs_drive), .hs_window(hs_window), .step(step)
);

// File: tb/lane_hs_seq_tb.sv
module lane_hs_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hs_en = 1'b0, ulp_en = 1'b0, wake = 1'b0;
  logic [31:0] w0 = '0, w1 = '0, w2 = '0, w3 = '0;
  logic [1:0] lp_d, lp_c;
  logic drv_d, drv_c, win_d, win_c;
  logic [3:0] st_d, st_c;
  logic sel = 1'b0;
  int checks = 0, fails = 0;
  int cyc = 0;
  bit done_flag = 1'b0;

  always #2.5 clk = ~clk;

  lane_hs_seq #(.CLOCK_LANE(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .hs_en(hs_en), .ulp_en(ulp_en), .wake(wake),
    .tim_w0(w0), .tim_w1(w1), .tim_w2(w2), .tim_w3(w3),
    .lp_line(lp_d), .hs_drive(drv_d), .hs_window(win_d), .step(st_d));

  lane_hs_seq #(.CLOCK_LANE(1'b1)) u_dut_ck (
    .clk(clk), .rst_n(rst_n), .hs_en(hs_en), .ulp_en(ulp_en), .wake(wake),
    .tim_w0(w0), .tim_w1(w1), .tim_w2(w2), .tim_w3(w3),
    .lp_line(lp_c), .hs_drive(drv_c), .hs_window(win_c), .step(st_c));

  wire [3:0] st  = sel ? st_c  : st_d;
  wire [1:0] lp  = sel ? lp_c  : lp_d;
  wire       drv = sel ? drv_c : drv_d;
  wire       win = sel ? win_c : win_d;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  // expected output levels per step code, from the requirement table
  task automatic chk_levels(input string req);
    int elp, edrv, ewin;
    case (st)
      4'd0, 4'd6: elp = 3;
      4'd1:       elp = 1;
      4'd8:       elp = 2;
      default:    elp = 0;
    endcase
    edrv = (st == 4'd3 || st == 4'd4 || st == 4'd5) ? 1 : 0;
    ewin = (st == 4'd4) ? 1 : 0;
    chk(req, {lp, drv, win}, {elp[1:0], edrv[0], ewin[0]});
  endtask

  task automatic run_len(input logic [3:0] code, input string req, input int exp);
    int n = 0;
    chk({req, " step code"}, st, code);
    chk_levels(req);
    while (st == code && n < 600) begin
      n++;
      @(negedge clk);
    end
    chk({req, " run length"}, n, exp);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; hs_en = 1'b0; ulp_en = 1'b0; wake = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // full entry and exit; drop_early exercises R8
  task automatic hs_cycle(input logic lane, input int l, input int p, input int z,
                          input int t, input int x, input bit drop_early);
    sel = lane;
    if (lane) begin
      w0 = {24'h0, l[7:0]};
      w1 = {8'd99, 24'h0};               // data-lane exit, must be ignored (R7)
      w2 = {t[7:0], z[7:0], 16'h0};
      w3 = {8'h0, x[7:0], 8'h0, p[7:0]};
    end else begin
      w0 = {t[7:0], z[7:0], p[7:0], l[7:0]};
      w1 = {x[7:0], 24'h0};
      w2 = {8'd77, 8'd77, 16'h0};        // clock-lane fields, must be ignored (R6)
      w3 = {8'h0, 8'd77, 8'h0, 8'd77};
    end
    do_reset();
    chk("R1 reset step", st, 0);
    chk_levels("R1");
    hs_en = 1'b1;
    @(negedge clk);
    if (drop_early) hs_en = 1'b0;
    run_len(4'd1, lane ? "R7 R5 R2 lpx" : "R6 R5 R2 lpx", eff(l));
    run_len(4'd2, lane ? "R7 R5 R2 prep" : "R6 R5 R2 prep", eff(p));
    run_len(4'd3, lane ? "R7 R5 R3 zero" : "R6 R5 R3 zero", eff(z));
    chk("R8 R3 reached hs", st, 4);
    chk_levels("R3");
    if (!drop_early) begin
      ulp_en = 1'b1;
      repeat (3) begin
        @(negedge clk);
        chk("R9 hs hold", st, 4);
      end
      ulp_en = 1'b0;
      hs_en = 1'b0;
      @(negedge clk);
    end else begin
      @(negedge clk);
    end
    run_len(4'd5, lane ? "R7 R5 R4 trail" : "R6 R5 R4 trail", eff(t));
    run_len(4'd6, lane ? "R7 R5 R4 exit" : "R6 R5 R4 exit", eff(x));
    chk("R4 back to stop", st, 0);
    chk_levels("R4");
  endtask

  task automatic ulp_test();
    sel = 1'b0;
    w0 = 32'h0302_0201; w1 = 32'h0100_0000;
    do_reset();
    ulp_en = 1'b1; hs_en = 1'b1;
    @(negedge clk);
    chk("R10 sleep wins over hs", st, 7);
    chk_levels("R10");
    hs_en = 1'b0;
    wake = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk("R11 wake ignored while sleep enabled", st, 7);
    end
    wake = 1'b0;
    ulp_en = 1'b0;
    repeat (2) begin
      @(negedge clk);
      chk("R11 sleep holds without wake", st, 7);
    end
    wake = 1'b1;
    @(negedge clk);
    chk("R11 mark step", st, 8);
    chk_levels("R11");
    @(negedge clk);
    chk("R11 mark holds while wake high", st, 8);
    wake = 1'b0;
    @(negedge clk);
    chk("R11 back to stop", st, 0);
    chk_levels("R11");
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done_flag) begin
      done_flag = 1'b1;
      fails++; checks++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int vals[4] = '{0, 1, 2, 5};
    // data lane sweep over all combinations of a small value set
    foreach (vals[a]) foreach (vals[b]) foreach (vals[c])
      hs_cycle(1'b0, vals[a], vals[b], vals[c], vals[(a + b) % 4], vals[(b + c) % 4], 1'b0);
    foreach (vals[a]) foreach (vals[b])
      hs_cycle(1'b0, vals[(a + b) % 4], vals[a], vals[b], vals[a], vals[b], 1'b0);
    // clock lane sweep
    foreach (vals[a]) foreach (vals[b]) foreach (vals[c])
      hs_cycle(1'b1, vals[c], vals[a], vals[b], vals[(a + c) % 4], vals[(a + b) % 4], 1'b0);
    // entry not interruptible
    hs_cycle(1'b0, 3, 2, 4, 2, 3, 1'b1);
    hs_cycle(1'b1, 2, 3, 1, 3, 2, 1'b1);
    ulp_test();
    done_flag = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule